// File: doc/BRIEF.md
# Four-Phase Multiplexed Bus Handshake Pair

This block joins a bus master and a bus slave over a shared set of address/data lines whose control is an unclocked request/acknowledge handshake. A local client hands the master one transaction at a time: a target address, a direction and, for a write, a data word. The master puts the address on the shared lines and marks it with an address strobe. It holds that address long enough for the strobe to cross into the slave's clock domain and for the slave to decode it. It then raises request. On a write, the master replaces the address with the write word at that point. On a read, it lets go of the lines.

The slave owns a small window of word registers. It captures the address when the strobe arrives and checks it against its window. Once request is seen, it either stores the write word or drives the stored word back, and it raises acknowledge. The master drops request once it sees acknowledge, capturing the read word at that moment. The slave then drops acknowledge and stops driving the lines. A request that no slave answers ends after a programmable number of cycles with an error response. Each side brings the other side's control lines in through a two-flop synchronizer. Undriven lines read as zero in this model, and two driver-enable outputs show which side owns the lines in each cycle.

Top module: `hs_bus_pair`

## Requirements
- R1: While reset is asserted and right after it, cmd_ready is 1 and bus_req, bus_ack, bus_m_en, bus_s_en and rsp_valid are all 0.
- R2: The cycle after a command is accepted, the shared lines carry cmd_addr with bus_ale=1, bus_m_en=1 and bus_dir equal to cmd_write (1 = write, 0 = read). The strobe stays high for exactly SYNC_STAGES+DECODE_WAIT cycles (4 by default). bus_req rises in the cycle the strobe falls.
- R3: On a write, the master drives the write word on the shared lines (bus_m_en=1) while bus_req is high. A slave that decodes the address stores the word before it raises bus_ack.
- R4: On a read, the master releases the shared lines while bus_req is high. The slave drives the addressed word with bus_s_en=1 in every cycle bus_ack is high. The master returns that word on rsp_rdata with rsp_err=0.
- R5: Request is dropped only after acknowledge has been seen or the timeout has expired. Acknowledge falls only while request is low.
- R6: bus_s_en is never high while bus_ack is low, so the slave stops driving in the same cycle acknowledge falls.
- R7: bus_m_en and bus_s_en are never high together.
- R8: The master accepts no command (cmd_ready=1) while bus_ack is high.
- R9: If no acknowledge arrives, bus_req stays high for exactly tmo_cycles cycles (tmo_cycles=0 disables the limit). The response then has rsp_err=1 and rsp_rdata=0.
- R10: The slave answers only addresses in BASE..BASE+DEPTH-1 (0x40..0x47 by default), with word index addr-BASE. Writes to other addresses change no stored word.
- R11: Each command yields exactly one single-cycle rsp_valid pulse. rsp_rdata is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle and able to accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | W | Target address |
| cmd_wdata | input | W | Write word |
| tmo_cycles | input | TW | Request timeout in cycles, 0 = none |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | W | Read word, 0 for writes and errors |
| rsp_err | output | 1 | No acknowledge before timeout |
| bus_ad | output | W | Shared address/data lines (resolved) |
| bus_ale | output | 1 | Address strobe from master |
| bus_dir | output | 1 | Direction line from master |
| bus_req | output | 1 | Request line |
| bus_ack | output | 1 | Acknowledge line |
| bus_m_en | output | 1 | Master driving shared lines |
| bus_s_en | output | 1 | Slave driving shared lines |

## Verification
The bench counts address-strobe cycles before request rises. A master that skips the decode wait, or that raises request early, shows a short count, and a slave fed that way would latch data as an address. Window edges (the word below BASE, the first and last mapped words, and BASE+DEPTH) are exercised. An off-by-one decode would acknowledge an unmapped address, so no timeout would occur, or would time out on a mapped one. Writes to unmapped addresses are followed by reads of mapped words, exposing any aliased store. Timeouts are measured in request-high cycles, and every cycle is watched for two drivers on the lines, a slave driving after acknowledge falls, and a command accepted under a high acknowledge.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_ADDR = 2'd1,
    M_REQ  = 2'd2,
    M_REL  = 2'd3
  } mst_state_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_ACK  = 2'd2
  } slv_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int W           = 16,
  parameter int DECODE_WAIT = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [W-1:0]  cmd_addr_i,
  input  logic [W-1:0]  cmd_wdata_i,
  input  logic [TW-1:0] tmo_i,
  output logic          rsp_valid_o,
  output logic [W-1:0]  rsp_rdata_o,
  output logic          rsp_err_o,
  input  logic [W-1:0]  bus_i,
  output logic [W-1:0]  drv_o,
  output logic          en_o,
  output logic          ale_o,
  output logic          dir_o,
  output logic          req_o,
  input  logic          ack_i
);
  localparam int HOLD = SYNC_STAGES + DECODE_WAIT;
  localparam int CW   = $clog2(HOLD + 1);

  mst_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [W-1:0]  addr_q, addr_d, wdata_q, wdata_d, rdata_q, rdata_d;
  logic          wr_q, wr_d, err_q, err_d, vld_q, vld_d;
  logic          ack_s, tmo_hit;

  hs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ack_i), .q_o(ack_s)
  );

  assign tmo_hit = (tmo_i != '0) && (tmr_q == tmo_i - 1'b1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tmr_d   = tmr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    wr_d    = wr_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    vld_d   = 1'b0;
    unique case (state_q)
      M_IDLE: if (cmd_valid_i) begin
        addr_d  = cmd_addr_i;
        wdata_d = cmd_wdata_i;
        wr_d    = cmd_write_i;
        cnt_d   = '0;
        state_d = M_ADDR;
      end
      M_ADDR: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(HOLD - 1)) begin
          tmr_d   = '0;
          state_d = M_REQ;
        end
      end
      M_REQ: begin
        tmr_d = tmr_q + 1'b1;
        if (ack_s) begin
          err_d   = 1'b0;
          rdata_d = wr_q ? '0 : bus_i;
          state_d = M_REL;
        end else if (tmo_hit) begin
          err_d   = 1'b1;
          rdata_d = '0;
          state_d = M_REL;
        end
      end
      M_REL: if (!ack_s) begin
        vld_d   = 1'b1;
        state_d = M_IDLE;
      end
      default: state_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      tmr_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tmr_q   <= tmr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      wr_q    <= wr_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
      vld_q   <= vld_d;
    end
  end

  assign cmd_ready_o = (state_q == M_IDLE);
  assign ale_o       = (state_q == M_ADDR);
  assign req_o       = (state_q == M_REQ);
  assign en_o        = (state_q == M_ADDR) || ((state_q == M_REQ) && wr_q);
  assign drv_o       = (state_q == M_ADDR) ? addr_q : wdata_q;
  assign dir_o       = wr_q && (state_q != M_IDLE);
  assign rsp_valid_o = vld_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;

  // R2: request only rises straight out of the address phase
  a_r2_req_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(ale_o));
  // R5: request dropped only once acknowledge was seen or time ran out
  a_r5_req_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> (ack_s || err_q));
  // R8: idle master never faces a high acknowledge
  a_r8_idle_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> !ack_i);
  // R9: error responses carry no data
  a_r9_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0));
  // R11: response is a single-cycle pulse
  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int          W           = 16,
  parameter int          DEPTH       = 8,
  parameter int unsigned BASE        = 'h40,
  parameter int          SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_i,
  input  logic         ale_i,
  input  logic         dir_i,
  input  logic         req_i,
  output logic         ack_o,
  output logic         en_o,
  output logic [W-1:0] drv_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [W-1:0] BASE_W  = W'(BASE);
  localparam logic [W-1:0] DEPTH_W = W'(DEPTH);

  slv_state_e   state_q, state_d;
  logic [W-1:0] addr_q, addr_d, off;
  logic         wr_q, wr_d, ale_s, req_s, ale_prev_q, ale_rise, hit, we;
  logic [IW-1:0] idx;
  logic [DEPTH-1:0][W-1:0] words;

  hs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d_i({ale_i, req_i}), .q_o({ale_s, req_s})
  );

  assign ale_rise = ale_s && !ale_prev_q;
  assign off      = addr_q - BASE_W;
  assign hit      = (addr_q >= BASE_W) && (off < DEPTH_W);
  assign idx      = off[IW-1:0];

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    wr_d    = wr_q;
    we      = 1'b0;
    unique case (state_q)
      S_IDLE, S_ADDR: begin
        if (ale_rise) begin
          addr_d  = bus_i;
          wr_d    = dir_i;
          state_d = S_ADDR;
        end else if ((state_q == S_ADDR) && req_s && hit) begin
          we      = wr_q;
          state_d = S_ACK;
        end
      end
      S_ACK: if (!req_s) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      wr_q       <= 1'b0;
      ale_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      addr_q     <= addr_d;
      wr_q       <= wr_d;
      ale_prev_q <= ale_s;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (we && (idx == IW'(i))) word_q <= bus_i;
    end
    assign words[i] = word_q;
  end

  assign ack_o = (state_q == S_ACK);
  assign en_o  = (state_q == S_ACK) && !wr_q;
  assign drv_o = words[idx];

  // R6: slave drives only while acknowledging
  a_r6_drive_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> ack_o);
  // R5: acknowledge falls only with request already low
  a_r5_ack_fall_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !req_i);
  // R10: acknowledge only for a decoded address
  a_r10_ack_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(hit));
endmodule

// File: rtl/hs_bus_pair.sv
module hs_bus_pair #(
  parameter int          W           = 16,
  parameter int          DEPTH       = 8,
  parameter int unsigned BASE        = 'h40,
  parameter int          DECODE_WAIT = 2,
  parameter int          SYNC_STAGES = 2,
  parameter int          TW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [W-1:0]  cmd_addr,
  input  logic [W-1:0]  cmd_wdata,
  input  logic [TW-1:0] tmo_cycles,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_rdata,
  output logic          rsp_err,
  output logic [W-1:0]  bus_ad,
  output logic          bus_ale,
  output logic          bus_dir,
  output logic          bus_req,
  output logic          bus_ack,
  output logic          bus_m_en,
  output logic          bus_s_en
);
  logic [W-1:0] m_drv, s_drv;

  hs_master #(.W(W), .DECODE_WAIT(DECODE_WAIT), .SYNC_STAGES(SYNC_STAGES), .TW(TW)) u_mst (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .tmo_i(tmo_cycles),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .bus_i(bus_ad), .drv_o(m_drv), .en_o(bus_m_en), .ale_o(bus_ale),
    .dir_o(bus_dir), .req_o(bus_req), .ack_i(bus_ack)
  );

  hs_slave #(.W(W), .DEPTH(DEPTH), .BASE(BASE), .SYNC_STAGES(SYNC_STAGES)) u_slv (
    .clk(clk), .rst_n(rst_n),
    .bus_i(bus_ad), .ale_i(bus_ale), .dir_i(bus_dir), .req_i(bus_req),
    .ack_o(bus_ack), .en_o(bus_s_en), .drv_o(s_drv)
  );

  assign bus_ad = bus_m_en ? m_drv : (bus_s_en ? s_drv : '0);

  // R7: never two drivers on the shared lines
  a_r7_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_m_en, bus_s_en}));
endmodule

// File: tb/hs_bus_pair_test.sv
module hs_bus_pair_test;
  localparam int W = 16, DEPTH = 8, TW = 8;
  localparam int BASE = 'h40, HOLD = 4, TMO = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [W-1:0] cmd_addr = '0, cmd_wdata = '0;
  logic [TW-1:0] tmo_cycles = TW'(TMO);
  logic cmd_ready, rsp_valid, rsp_err, bus_ale, bus_dir, bus_req, bus_ack, bus_m_en, bus_s_en;
  logic [W-1:0] rsp_rdata, bus_ad;

  int total = 0, failed = 0;
  int mon_r6 = 0, mon_r7 = 0, mon_r8 = 0;
  logic [W-1:0] model [DEPTH];

  always #5 clk = ~clk;

  hs_bus_pair uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .tmo_cycles(tmo_cycles), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .bus_ad(bus_ad), .bus_ale(bus_ale), .bus_dir(bus_dir),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_m_en(bus_m_en), .bus_s_en(bus_s_en)
  );

  function automatic bit in_window(input logic [W-1:0] a);
    return (a >= W'(BASE)) && (a < W'(BASE + DEPTH));
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [W-1:0] a);
    return in_window(a) ? model[a - W'(BASE)] : '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_s_en && !bus_ack) mon_r6++;
    if (bus_s_en && bus_m_en) mon_r7++;
    if (cmd_ready && bus_ack) mon_r8++;
  end

  task automatic txn(input bit wr, input logic [W-1:0] a, input logic [W-1:0] wd, input int tmo);
    bit hit = in_window(a);
    bit ack_seen = 0;
    int n, rq;
    logic [W-1:0] exp_rd = wr ? '0 : exp_read(a);
    tmo_cycles = TW'(tmo);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(bus_ale && bus_m_en && bus_ad == a && bus_dir == wr, "R2 address phase lines",
        {bus_ale, bus_m_en, bus_dir, 13'd0, bus_ad}, {1'b1, 1'b1, wr, 13'd0, a});
    n = 0;
    while (bus_ale) begin n++; @(negedge clk); end
    chk(n == HOLD, "R2 strobe length", n, HOLD);
    chk(bus_req, "R2 request rises as strobe falls", bus_req, 1);
    if (wr) chk(bus_m_en && bus_ad == wd, "R3 write word on lines", bus_ad, wd);
    else    chk(!bus_m_en, "R4 master releases lines on read", bus_m_en, 0);
    rq = 0;
    while (bus_req) begin
      rq++;
      if (bus_ack && !ack_seen) begin
        ack_seen = 1;
        if (!wr) chk(bus_s_en && bus_ad == exp_rd, "R4 slave drives word with ack", bus_ad, exp_rd);
      end
      @(negedge clk);
    end
    if (hit) chk(ack_seen, "R5 request held until ack", ack_seen, 1);
    else begin
      chk(!ack_seen, "R10 no ack outside window", ack_seen, 0);
      chk(rq == tmo, "R9 request cycles on timeout", rq, tmo);
    end
    while (!rsp_valid) @(negedge clk);
    chk(rsp_err == !hit, "R9 error flag", rsp_err, !hit);
    chk(rsp_rdata == exp_rd, wr ? "R11 write response data" : "R4 read response data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_valid, "R11 single pulse", rsp_valid, 0);
    if (wr && hit) model[a - W'(BASE)] = wd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !bus_req && !bus_ack && !bus_m_en && !bus_s_en && !rsp_valid,
        "R1 state in reset", {cmd_ready, bus_req, bus_ack, bus_m_en, bus_s_en, rsp_valid}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !bus_req && !bus_ack && !rsp_valid, "R1 state after reset",
        {cmd_ready, bus_req, bus_ack, rsp_valid}, 4'b1000);
    // directed window edges
    txn(1, W'(BASE), 16'hA5A5, TMO);
    txn(1, W'(BASE + DEPTH - 1), 16'h5A5A, TMO);
    txn(0, W'(BASE), '0, TMO);
    txn(0, W'(BASE + DEPTH - 1), '0, TMO);
    txn(1, W'(BASE - 1), 16'hDEAD, TMO);      // R10 ignored write below window
    txn(1, W'(BASE + DEPTH), 16'hBEEF, 5);     // R9 short timeout above window
    txn(0, W'(BASE), '0, TMO);                 // R10 stored words unchanged
    txn(0, W'(BASE + DEPTH - 1), '0, TMO);
    txn(0, 16'h0000, '0, 3);
    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [W-1:0] a;
      if ($urandom_range(0, 4) != 0) a = W'(BASE) + W'($urandom_range(0, DEPTH - 1));
      else a = W'($urandom_range(BASE + DEPTH, 16'hFFFF));
      txn($urandom_range(0, 1), a, W'($urandom), TMO);
    end
    for (int i = 0; i < DEPTH; i++) txn(0, W'(BASE + i), '0, TMO);
    chk(mon_r6 == 0, "R6 slave driving without ack", mon_r6, 0);
    chk(mon_r7 == 0, "R7 two drivers", mon_r7, 0);
    chk(mon_r8 == 0, "R8 ready while ack high", mon_r8, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule